// File: doc/BRIEF.md
# Delay Slot Nullify Controller

This block sits beside the decode stage of a five-stage pipeline whose branches resolve in decode and which always has a single delay slot. When a branch is decoded, the block drives the next-PC select in the same cycle. It also remembers what must happen to the instruction that follows in the slot. That slot instruction can be one of two things: a normal instruction that commits, or a no-op whose valid bit is cleared before any state is written.

There are three branch kinds:
- A plain delayed branch always lets its slot run.
- A canceling branch carries a predicted-direction bit. Its slot runs only if the resolved outcome agrees with that bit.
- A likely-taken branch runs its slot only when it is taken.

In every case, fetch after the slot goes to the target when the branch is taken and stays sequential when it is not. A branch decoded inside a delay slot is illegal. It is flagged, and it neither redirects fetch nor opens a slot of its own.

Top module: `dslot_ctrl`

## Requirements
- R1: After reset, no slot is pending: slot_o, nullify_o and illegal_o are 0, and a valid instruction passes with exec_valid_o equal to dec_valid_i.
- R2: Branch kind code 2'b00 (not a branch) never drives pc_sel_o and does not make the next instruction a slot.
- R3: Kind 2'b01 (plain delayed): the slot instruction always executes, whether the branch is taken or not.
- R4: Kind 2'b10 (canceling): the slot is nullified exactly when br_taken_i differs from pred_taken_i.
- R5: Kind 2'b11 (likely-taken): the slot is nullified exactly when the branch is untaken, and pred_taken_i has no effect.
- R6: The slot is the next cycle with dec_valid_i high after the branch. Cycles with dec_valid_i low in between leave the pending slot unchanged. The instruction after the slot is never treated as a slot.
- R7: When the slot is nullified, nullify_o is 1 and exec_valid_o is 0 in the slot's decode cycle.
- R8: A valid branch (kind not 2'b00) decoded while slot_o is 1 raises illegal_o in that cycle. It does not drive pc_sel_o, and the following instruction is not a slot.
- R9: pc_sel_o (1 = target, 0 = sequential) is 1 in the branch's own decode cycle exactly when a legal valid branch is resolved taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | Valid instruction in decode this cycle |
| br_kind_i | input | 2 | Branch kind: 00 none, 01 plain, 10 canceling, 11 likely-taken |
| pred_taken_i | input | 1 | Predicted-direction bit from a canceling branch encoding |
| br_taken_i | input | 1 | Resolved outcome of the branch in decode |
| pc_sel_o | output | 1 | Next-PC select: 1 target, 0 sequential |
| slot_o | output | 1 | The next valid decode is a delay slot |
| nullify_o | output | 1 | The slot instruction in decode is turned into a no-op |
| exec_valid_o | output | 1 | Valid bit passed on to the later stages |
| illegal_o | output | 1 | Branch found in a delay slot |

## Verification
The corner cases are:
- Each canceling branch with every pairing of prediction and outcome. A design that compared the wrong bits would kill correct-path slots.
- Likely-taken branches with the prediction bit forced both ways. A design that read that bit would let untaken slots commit.
- Bubbles inserted between a branch and its slot. A design that consumed the slot on an invalid cycle would apply the nullify to the wrong instruction.
- Branches placed back to back. A design that let an illegal slot branch open a new slot would wrongly kill or redirect the instruction after it.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  typedef enum logic [1:0] {
    BK_NONE   = 2'b00,
    BK_PLAIN  = 2'b01,
    BK_CANCEL = 2'b10,
    BK_LIKELY = 2'b11
  } br_kind_e;
endpackage

// File: rtl/dslot_policy.sv
module dslot_policy
  import dslot_pkg::*;
(
  input  br_kind_e kind_i,
  input  logic     pred_i,
  input  logic     taken_i,
  output logic     is_br_o,
  output logic     redirect_o,
  output logic     kill_o
);
  always_comb begin
    is_br_o    = (kind_i != BK_NONE);
    redirect_o = is_br_o & taken_i;
    unique case (kind_i)
      BK_CANCEL: kill_o = (taken_i != pred_i);
      BK_LIKELY: kill_o = ~taken_i;
      default:   kill_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dslot_tracker.sv
module dslot_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic open_i,
  input  logic kill_i,
  output logic in_slot_o,
  output logic kill_o
);
  logic in_slot_q, kill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_slot_q <= 1'b0;
      kill_q    <= 1'b0;
    end else if (adv_i) begin
      in_slot_q <= open_i;
      kill_q    <= open_i & kill_i;
    end
  end

  assign in_slot_o = in_slot_q;
  assign kill_o    = kill_q;

  // R6
  hold_on_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(in_slot_q) && $stable(kill_q));
  // R6
  slot_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && open_i) |=> in_slot_q);
  // R6
  slot_consumed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && in_slot_q && !open_i) |=> !in_slot_q);
endmodule

// File: rtl/dslot_ctrl.sv
module dslot_ctrl
  import dslot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dec_valid_i,
  input  logic [1:0] br_kind_i,
  input  logic       pred_taken_i,
  input  logic       br_taken_i,
  output logic       pc_sel_o,
  output logic       slot_o,
  output logic       nullify_o,
  output logic       exec_valid_o,
  output logic       illegal_o
);
  logic is_br, redirect, kill_now;
  logic in_slot, kill_slot, legal_br;

  dslot_policy u_policy (
    .kind_i    (br_kind_e'(br_kind_i)),
    .pred_i    (pred_taken_i),
    .taken_i   (br_taken_i),
    .is_br_o   (is_br),
    .redirect_o(redirect),
    .kill_o    (kill_now)
  );

  // a branch sitting in a slot is dropped: no redirect, no new slot
  assign legal_br = dec_valid_i & is_br & ~in_slot;

  dslot_tracker u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (dec_valid_i),
    .open_i   (is_br & ~in_slot),
    .kill_i   (kill_now),
    .in_slot_o(in_slot),
    .kill_o   (kill_slot)
  );

  assign pc_sel_o     = legal_br & redirect;
  assign slot_o       = in_slot;
  assign nullify_o    = dec_valid_i & in_slot & kill_slot;
  assign exec_valid_o = dec_valid_i & ~nullify_o;
  assign illegal_o    = dec_valid_i & in_slot & is_br;

  // R8
  illegal_no_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !pc_sel_o);
  // R8
  illegal_no_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !slot_o);
  // R7
  nullify_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nullify_o |-> !exec_valid_o);
  // R3
  plain_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !slot_o && br_kind_i == 2'b01) |=> !kill_slot);
  // R5
  likely_untaken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !slot_o && br_kind_i == 2'b11 && !br_taken_i) |=> kill_slot);
endmodule

// File: tb/sim_dslot_ctrl.sv
`timescale 1ns/1ps
module sim_dslot_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 1'b0, p = 1'b0, tk = 1'b0;
  logic [1:0] k = 2'b00;
  logic pc_sel, slot, nul, exv, ill;
  int checks = 0, fails = 0;
  logic m_slot = 1'b0, m_kill = 1'b0;

  always #2 clk = ~clk;

  dslot_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(v), .br_kind_i(k),
    .pred_taken_i(p), .br_taken_i(tk), .pc_sel_o(pc_sel), .slot_o(slot),
    .nullify_o(nul), .exec_valid_o(exv), .illegal_o(ill)
  );

  function automatic logic exp_kill(logic [1:0] kind, logic pr, logic t);
    case (kind)
      2'b10:   return t != pr;
      2'b11:   return !t;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b", tag, nm, act, exp);
    end
  endtask

  // drive after negedge, check, then let the edge update the model
  task automatic step(logic vv, logic [1:0] kk, logic pp, logic tt, string tag);
    logic e_nul;
    @(negedge clk);
    v = vv; k = kk; p = pp; tk = tt;
    #1;
    e_nul = vv & m_slot & m_kill;
    chk(tag, "slot_o R6", slot, m_slot);
    chk(tag, "nullify_o R7", nul, e_nul);
    chk(tag, "exec_valid_o R7", exv, vv & ~e_nul);
    chk(tag, "illegal_o R8", ill, vv & m_slot & (kk != 2'b00));
    chk(tag, "pc_sel_o R9", pc_sel, vv & (kk != 2'b00) & ~m_slot & tt);
    @(posedge clk);
    if (vv) begin
      m_kill = (kk != 2'b00) & ~m_slot & exp_kill(kk, pp, tt);
      m_slot = (kk != 2'b00) & ~m_slot;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #5;
    chk("R1", "slot_o", slot, 1'b0);
    chk("R1", "nullify_o", nul, 1'b0);
    chk("R1", "illegal_o", ill, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(1, 2'b00, 0, 1, "R1");
    step(1, 2'b00, 1, 1, "R2");
    step(1, 2'b00, 0, 0, "R2");
    // plain: slot runs both ways
    step(1, 2'b01, 0, 1, "R3"); step(1, 2'b00, 0, 0, "R3");
    step(1, 2'b01, 1, 0, "R3"); step(1, 2'b00, 0, 0, "R3");
    // canceling: all four pairings
    for (int i = 0; i < 4; i++) begin
      step(1, 2'b10, i[1], i[0], "R4");
      step(1, 2'b00, 0, 0, "R4");
    end
    // likely-taken with pred bit forced both ways
    for (int i = 0; i < 4; i++) begin
      step(1, 2'b11, i[1], i[0], "R5");
      step(1, 2'b00, 0, 0, "R5");
    end
    // bubbles between branch and slot
    step(1, 2'b11, 0, 0, "R6");
    step(0, 2'b01, 1, 1, "R6");
    step(0, 2'b00, 0, 0, "R6");
    step(1, 2'b00, 0, 0, "R6");
    step(1, 2'b00, 0, 0, "R6");
    // branch in slot, then its follower
    step(1, 2'b10, 1, 0, "R8");
    step(1, 2'b11, 0, 1, "R8");
    step(1, 2'b00, 0, 0, "R8");
    // random mix
    void'($urandom(32'd4242));
    for (int n = 0; n < 4000; n++) begin
      logic rv, rp, rt;
      logic [1:0] rk;
      rv = ($urandom % 5) != 0;
      rk = 2'($urandom);
      rp = 1'($urandom);
      rt = 1'($urandom);
      step(rv, rk, rp, rt, "R3 R4 R5 R6");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule